// File: doc/BRIEF.md
# Memory-Mapped Panel I/O Controller

This block is a small peripheral on an AXI4-Lite slave port. It connects a processor to a board's front panel. The register space holds eight 32-bit words. The processor writes two of them: an 8-bit value sent on to a seven-segment display driver, and an 8-bit pattern for eight LEDs. The other six words are read-only views of fabric-side state:

- the switch inputs,
- the button inputs,
- an up/down position counter driven by a quadrature rotary encoder,
- the encoder's push switch,
- the encoder's shaft button,
- a free-running timer that advances once per millisecond.

The switch, button and encoder inputs arrive already debounced and synchronous to the bus clock. The block runs on the bus clock and uses one active-low synchronous reset.

Software uses the block in three ways:

- It polls the timer to measure time.
- It reads the encoder count to follow knob movement.
- It writes the display and LED words to show results.

Bus flow control follows the AXI4-Lite rules:

- Each of the write-address and write-data channels accepts one beat when its ready is high. Ready drops while a beat is held and not yet committed.
- A write response stays valid until it is taken. Read data stays valid, and unchanged, until it is taken.
- A new read is accepted only when no read response is waiting.

Top module: `panel_io_axil`

## Requirements
- R1: While reset is low, the display value, the LED pattern, the encoder count, the timer prescaler and the timer are cleared. BVALID and RVALID are low, and AWREADY, WREADY and ARREADY are high.
- R2: A write to byte offset 0x00 with WSTRB bit 0 set loads WDATA[7:0] into the display value. A write to offset 0x04 with WSTRB bit 0 set loads WDATA[7:0] into the LED pattern. With WSTRB bit 0 clear, the register keeps its value. Upper data bytes are never stored.
- R3: Writes to offsets 0x08 through 0x1C change no register. They still receive an OKAY response (BRESP = 2'b00).
- R4: Reads return 32-bit words, zero-extended above each field. The register is selected by address bits [4:2]:
  - 0x00: display value.
  - 0x04: LED pattern.
  - 0x08: 8 switch bits.
  - 0x0C: 5 button bits.
  - 0x10: encoder count.
  - 0x14: encoder push switch, in bit 0.
  - 0x18: shaft button, in bit 0.
  - 0x1C: timer.
- R5: The AW and W beats may arrive in either order or together. The write takes effect on the first clock edge at which both are held and no response is pending. BVALID rises on that same edge with BRESP = 2'b00 and stays high until BREADY is seen.
- R6: ARREADY equals the inverse of RVALID. On an accepted read, RVALID rises on the handshake edge, and RDATA holds the register value from just before that edge. RDATA stays stable while RVALID is high and RREADY is low. RRESP = 2'b00.
- R7: The encoder count changes only on a clock edge at which input A is high and was low at the previous edge. It adds one if B is high at that edge and subtracts one if B is low. It wraps modulo 256, so 0 minus 1 gives 255.
- R8: Reset sets the A history to the rest level (high by default). An A input held high through reset therefore produces no count.
- R9: A prescaler counts clock edges from 0 to MS_LIMIT-1 and then wraps. On each wrap the timer advances by one. The timer read at a handshake edge equals the number of completed prescaler periods since reset was released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| seg_value | output | 8 | Value for the seven-segment driver |
| led_out | output | 8 | LED pattern |
| sw_in | input | SW_W | Switch states |
| btn_in | input | BTN_W | Button states |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| enc_sw | input | 1 | Encoder push switch |
| enc_btn | input | 1 | Encoder shaft button |

## Verification
Each result has a fixed due cycle:

- **Read data:** RVALID and RDATA appear on the edge that accepts the read address.
- **Writes:** a write lands one edge after both of its beats are held. BVALID and the new display or LED output appear on that same edge.
- **Encoder count:** it changes on the edge that first sees A high.
- **Timer:** it changes on the edge where the prescaler wraps.

A behavioural model in the bench applies these rules at every rising edge, from the same pre-edge inputs. All ready, valid, data and output pins are compared with it half a cycle later, at the falling edge.

Directed reads compare the timer with a count of clock edges since reset release. The bench records that count at the falling edge just before the handshake edge.

// File: rtl/panel_io_pkg.sv
package panel_io_pkg;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam int NREG   = 8;
  localparam int IDX_W  = $clog2(NREG);
  localparam int IDX_LSB = 2;
  localparam int VAL_W  = 8;

  typedef enum logic [IDX_W-1:0] {
    IDX_SEG  = 3'd0,
    IDX_LED  = 3'd1,
    IDX_SW   = 3'd2,
    IDX_BTN  = 3'd3,
    IDX_ENC  = 3'd4,
    IDX_ESW  = 3'd5,
    IDX_EBTN = 3'd6,
    IDX_TMR  = 3'd7
  } reg_idx_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/axil_wr_port.sv
module axil_wr_port
  import panel_io_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic                awvalid,
  output logic                awready,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [STRB_W-1:0]   wstrb,
  input  logic                wvalid,
  output logic                wready,
  output logic [1:0]          bresp,
  output logic                bvalid,
  input  logic                bready,
  output logic                wr_en,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [DATA_W-1:0]   wr_data,
  output logic [STRB_W-1:0]   wr_strb
);
  logic              aw_full, w_full, b_pend;
  logic [IDX_W-1:0]  aw_idx;
  logic [DATA_W-1:0] w_data;
  logic [STRB_W-1:0] w_strb;
  logic              unused_addr;

  assign unused_addr = ^{awaddr[ADDR_W-1:IDX_LSB+IDX_W], awaddr[IDX_LSB-1:0]};

  assign awready = !aw_full;
  assign wready  = !w_full;
  assign wr_en   = aw_full && w_full && !b_pend;
  assign wr_idx  = aw_idx;
  assign wr_data = w_data;
  assign wr_strb = w_strb;
  assign bvalid  = b_pend;
  assign bresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_full <= 1'b0;
      w_full  <= 1'b0;
      b_pend  <= 1'b0;
      aw_idx  <= '0;
      w_data  <= '0;
      w_strb  <= '0;
    end else begin
      if (awvalid && !aw_full) begin
        aw_full <= 1'b1;
        aw_idx  <= awaddr[IDX_LSB +: IDX_W];
      end else if (wr_en) begin
        aw_full <= 1'b0;
      end
      if (wvalid && !w_full) begin
        w_full <= 1'b1;
        w_data <= wdata;
        w_strb <= wstrb;
      end else if (wr_en) begin
        w_full <= 1'b0;
      end
      if (wr_en)                b_pend <= 1'b1;
      else if (b_pend && bready) b_pend <= 1'b0;
    end
  end

  AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid); // R5
  AST_COMMIT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bvalid && !awready == 1'b0 && bresp == RESP_OKAY)); // R5
endmodule

// File: rtl/axil_rd_port.sv
module axil_rd_port
  import panel_io_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            araddr,
  input  logic                         arvalid,
  output logic                         arready,
  output logic [DATA_W-1:0]            rdata,
  output logic [1:0]                   rresp,
  output logic                         rvalid,
  input  logic                         rready,
  input  logic [NREG-1:0][DATA_W-1:0]  bank
);
  logic              r_pend;
  logic [DATA_W-1:0] r_data;
  logic              unused_addr;

  assign unused_addr = ^{araddr[ADDR_W-1:IDX_LSB+IDX_W], araddr[IDX_LSB-1:0]};

  assign arready = !r_pend;
  assign rvalid  = r_pend;
  assign rdata   = r_data;
  assign rresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_pend <= 1'b0;
      r_data <= '0;
    end else if (arvalid && !r_pend) begin
      r_pend <= 1'b1;
      r_data <= bank[araddr[IDX_LSB +: IDX_W]];
    end else if (r_pend && rready) begin
      r_pend <= 1'b0;
    end
  end

  AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata))); // R6
  AST_AR_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && arready) |=> rvalid); // R6
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter #(
  parameter int ENC_W  = 8,
  parameter bit A_REST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_in,
  input  logic             b_in,
  output logic [ENC_W-1:0] count
);
  logic a_q;
  logic a_rise;

  assign a_rise = !a_q && a_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q   <= A_REST;
      count <= '0;
    end else begin
      a_q <= a_in;
      if (a_rise) begin
        if (b_in) count <= count + 1'b1;
        else      count <= count - 1'b1;
      end
    end
  end

  AST_ENC_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rise && b_in) |=> count == ENC_W'($past(count) + 1'b1)); // R7
  AST_ENC_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rise && !b_in) |=> count == ENC_W'($past(count) - 1'b1)); // R7
  AST_ENC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rise |=> $stable(count)); // R8
endmodule

// File: rtl/ms_tick_timer.sv
module ms_tick_timer #(
  parameter int MS_LIMIT = 100000,
  parameter int TMR_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [TMR_W-1:0] timer
);
  localparam int PW = (MS_LIMIT > 1) ? $clog2(MS_LIMIT) : 1;
  localparam logic [PW-1:0] LAST = PW'(MS_LIMIT - 1);

  logic [PW-1:0] presc;
  logic          tick;

  assign tick = (presc == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0;
      timer <= '0;
    end else begin
      presc <= tick ? '0 : presc + 1'b1;
      if (tick) timer <= timer + 1'b1;
    end
  end

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> timer == TMR_W'($past(timer) + 1'b1)); // R9
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(timer)); // R9
  AST_PRESC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> presc == '0); // R9
endmodule

// File: rtl/panel_io_axil.sv
module panel_io_axil
  import panel_io_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int MS_LIMIT = 100000,
  parameter int ENC_W    = 8,
  parameter int SW_W     = 8,
  parameter int BTN_W    = 5,
  parameter int TMR_W    = 32,
  parameter bit A_REST   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [7:0]        seg_value,
  output logic [7:0]        led_out,
  input  logic [SW_W-1:0]   sw_in,
  input  logic [BTN_W-1:0]  btn_in,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_sw,
  input  logic              enc_btn
);
  logic                        wr_en;
  logic [IDX_W-1:0]            wr_idx;
  logic [DATA_W-1:0]           wr_data;
  logic [STRB_W-1:0]           wr_strb;
  logic [VAL_W-1:0]            seg_q, led_q;
  logic [ENC_W-1:0]            enc_cnt;
  logic [TMR_W-1:0]            timer;
  logic [NREG-1:0][DATA_W-1:0] bank;
  logic                        unused_wr;

  assign unused_wr = ^{wr_data[DATA_W-1:VAL_W], wr_strb[STRB_W-1:1]};

  axil_wr_port #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  axil_rd_port #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .bank(bank)
  );

  quad_pos_counter #(.ENC_W(ENC_W), .A_REST(A_REST)) u_enc (
    .clk(clk), .rst_n(rst_n), .a_in(enc_a), .b_in(enc_b), .count(enc_cnt)
  );

  ms_tick_timer #(.MS_LIMIT(MS_LIMIT), .TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .timer(timer)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q <= '0;
      led_q <= '0;
    end else if (wr_en && wr_strb[0]) begin
      if (wr_idx == IDX_SEG) seg_q <= wr_data[VAL_W-1:0];
      if (wr_idx == IDX_LED) led_q <= wr_data[VAL_W-1:0];
    end
  end

  assign seg_value = seg_q;
  assign led_out   = led_q;

  always_comb begin
    bank           = '0;
    bank[IDX_SEG]  = DATA_W'(seg_q);
    bank[IDX_LED]  = DATA_W'(led_q);
    bank[IDX_SW]   = DATA_W'(sw_in);
    bank[IDX_BTN]  = DATA_W'(btn_in);
    bank[IDX_ENC]  = DATA_W'(enc_cnt);
    bank[IDX_ESW]  = DATA_W'(enc_sw);
    bank[IDX_EBTN] = DATA_W'(enc_btn);
    bank[IDX_TMR]  = DATA_W'(timer);
  end

  AST_RO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= IDX_SW) |=> ($stable(seg_value) && $stable(led_out))); // R3
  AST_STRB_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_strb[0]) |=> ($stable(seg_value) && $stable(led_out))); // R2
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(seg_value) && $stable(led_out))); // R2
endmodule

// File: tb/panel_io_axil_tb_top.sv
module panel_io_axil_tb_top;
  localparam int MSL = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic [7:0]  sw_in = '0;
  logic [4:0]  btn_in = '0;
  logic        enc_a = 1'b1, enc_b = 1'b0, enc_sw = 1'b0, enc_btn = 1'b0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [7:0]  seg_value, led_out;

  int tests = 0, fails = 0;
  int live = 0;
  bit done = 0;

  always #4 clk = ~clk;

  panel_io_axil #(.MS_LIMIT(MSL)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .seg_value(seg_value), .led_out(led_out),
    .sw_in(sw_in), .btn_in(btn_in),
    .enc_a(enc_a), .enc_b(enc_b), .enc_sw(enc_sw), .enc_btn(enc_btn)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, stepped at every rising edge.
  bit m_awf, m_wf, m_bv, m_rv, m_aprev;
  logic [2:0] m_aidx;
  logic [31:0] m_wd, m_rd, m_tmr;
  logic [3:0] m_ws;
  logic [7:0] m_seg, m_led, m_enc;
  int m_pre;

  function automatic logic [31:0] m_bank(input logic [2:0] i);
    case (i)
      3'd0: return {24'h0, m_seg};
      3'd1: return {24'h0, m_led};
      3'd2: return {24'h0, sw_in};
      3'd3: return {27'h0, btn_in};
      3'd4: return {24'h0, m_enc};
      3'd5: return {31'h0, enc_sw};
      3'd6: return {31'h0, enc_btn};
      default: return m_tmr;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_awf = 0; m_wf = 0; m_bv = 0; m_rv = 0; m_aprev = 1'b1;
      m_seg = 0; m_led = 0; m_enc = 0; m_tmr = 0; m_pre = 0; m_rd = 0;
      live = 0;
    end else begin
      bit old_awf, old_wf;
      live++;
      old_awf = m_awf; old_wf = m_wf;
      if (arvalid && !m_rv) begin m_rv = 1; m_rd = m_bank(araddr[4:2]); end
      else if (m_rv && rready) m_rv = 0;
      if (m_awf && m_wf && !m_bv) begin
        if (m_ws[0] && m_aidx == 3'd0) m_seg = m_wd[7:0];
        if (m_ws[0] && m_aidx == 3'd1) m_led = m_wd[7:0];
        m_awf = 0; m_wf = 0; m_bv = 1;
      end else if (m_bv && bready) m_bv = 0;
      if (awvalid && !old_awf) begin m_awf = 1; m_aidx = awaddr[4:2]; end
      if (wvalid && !old_wf) begin m_wf = 1; m_wd = wdata; m_ws = wstrb; end
      if (!m_aprev && enc_a) m_enc = enc_b ? m_enc + 8'd1 : m_enc - 8'd1;
      m_aprev = enc_a;
      if (m_pre == MSL - 1) begin m_pre = 0; m_tmr = m_tmr + 1; end
      else m_pre++;
    end
  end

  // Every-clock comparison at the falling edge (R5, R6, R2).
  always @(negedge clk) begin
    if (rst_n) begin
      bit ok;
      ok = (awready == !m_awf) && (wready == !m_wf) && (arready == !m_rv) &&
           (bvalid == m_bv) && (rvalid == m_rv) && (seg_value == m_seg) &&
           (led_out == m_led) && (!rvalid || (rdata == m_rd && rresp == 2'b00)) &&
           (!bvalid || bresp == 2'b00);
      chk(ok, "R5/R6 per-clock model", {bvalid, rvalid, seg_value, led_out, rdata},
          {m_bv, m_rv, m_seg, m_led, m_rd});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s,
                    input int mode, input int bhold);
    bit aw_done = 0, w_done = 0;
    @(negedge clk);
    if (mode != 2) begin awaddr = a; awvalid = 1; end
    if (mode != 1) begin wdata = d; wstrb = s; wvalid = 1; end
    for (int i = 0; i < 20 && !(aw_done && w_done); i++) begin
      bit aw_hs, w_hs;
      aw_hs = awvalid && awready;
      w_hs  = wvalid && wready;
      @(negedge clk);
      if (aw_hs) begin awvalid = 0; aw_done = 1; end
      if (w_hs)  begin wvalid = 0; w_done = 1; end
      if (i == 1 && !aw_done && !awvalid) begin awaddr = a; awvalid = 1; end
      if (i == 1 && !w_done && !wvalid) begin wdata = d; wstrb = s; wvalid = 1; end
    end
    for (int i = 0; i < 10 && !bvalid; i++) @(negedge clk);
    repeat (bhold) @(negedge clk);
    chk(bvalid && bresp == 2'b00, "R5 write response OKAY held", {bvalid, bresp}, 3'b100);
    bready = 1;
    @(negedge clk);
    bready = 0;
  endtask

  task automatic rd(input logic [4:0] a, input int rhold, output logic [31:0] d, output int at);
    @(negedge clk);
    araddr = a; arvalid = 1;
    at = live;
    @(negedge clk);
    arvalid = 0;
    d = rdata;
    chk(rvalid && rresp == 2'b00, "R6 read valid on handshake edge", {rvalid, rresp}, 3'b100);
    repeat (rhold) @(negedge clk);
    chk(rvalid && rdata == d, "R6 read data held", rdata, d);
    rready = 1;
    @(negedge clk);
    rready = 0;
  endtask

  task automatic enc_step(input logic b);
    @(negedge clk); enc_b = b; enc_a = 0;
    @(negedge clk); enc_a = 1;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] d, d2;
    int t, t2;
    repeat (4) @(negedge clk);
    chk(seg_value == 0 && led_out == 0, "R1 reset outputs", {seg_value, led_out}, 0);
    chk(!bvalid && !rvalid && awready && wready && arready, "R1 reset handshake",
        {bvalid, rvalid, awready, wready, arready}, 5'b00111);
    rst_n = 1;
    rd(5'h10, 0, d, t);
    chk(d == 0, "R8 no count with A at rest through reset", d, 0);
    rd(5'h1C, 0, d, t);
    chk(d == t / MSL, "R1 timer starts at zero", d, t / MSL);

    wr(5'h00, 32'hDEAD_BEA5, 4'b0001, 0, 0);
    chk(seg_value == 8'hA5, "R2 display write", seg_value, 8'hA5);
    rd(5'h00, 0, d, t);
    chk(d == 32'h0000_00A5, "R4 display readback zero-extended", d, 32'hA5);
    wr(5'h04, 32'hFFFF_FF3C, 4'b1111, 1, 0);
    chk(led_out == 8'h3C, "R5 AW-first LED write", led_out, 8'h3C);
    rd(5'h04, 0, d, t);
    chk(d == 32'h0000_003C, "R4 LED readback", d, 32'h3C);
    wr(5'h04, 32'h0000_0077, 4'b1110, 2, 0);
    chk(led_out == 8'h3C, "R2 strobe bit0 clear keeps LED", led_out, 8'h3C);
    wr(5'h00, 32'h0000_005A, 4'b0001, 2, 3);
    chk(seg_value == 8'h5A, "R5 W-first write with late BREADY", seg_value, 8'h5A);

    wr(5'h08, 32'hFFFF_FFFF, 4'b1111, 0, 0);
    wr(5'h1C, 32'h1234_5678, 4'b1111, 0, 0);
    wr(5'h10, 32'h0000_0055, 4'b1111, 1, 0);
    chk(seg_value == 8'h5A && led_out == 8'h3C, "R3 read-only writes ignored",
        {seg_value, led_out}, 16'h5A3C);
    rd(5'h10, 0, d, t);
    chk(d == 0, "R3 encoder unchanged by write", d, 0);

    sw_in = 8'h96; btn_in = 5'h15; enc_sw = 1; enc_btn = 1;
    rd(5'h08, 0, d, t);
    chk(d == 32'h96, "R4 switches", d, 32'h96);
    rd(5'h0C, 2, d, t);
    chk(d == 32'h15, "R4 buttons", d, 32'h15);
    rd(5'h14, 0, d, t);
    chk(d == 32'h1, "R4 encoder switch", d, 1);
    rd(5'h18, 0, d, t);
    chk(d == 32'h1, "R4 shaft button high", d, 1);
    enc_btn = 0; btn_in = 5'h1F;
    rd(5'h18, 3, d, t);
    chk(d == 32'h0, "R4 shaft button low", d, 0);
    rd(5'h0C, 0, d, t);
    chk(d == 32'h1F, "R4 all buttons", d, 32'h1F);

    repeat (3) enc_step(1'b1);
    rd(5'h10, 0, d, t);
    chk(d == 3, "R7 count up", d, 3);
    @(negedge clk); enc_b = 0;
    @(negedge clk); enc_b = 1;
    @(negedge clk);
    rd(5'h10, 0, d, t);
    chk(d == 3, "R7 B toggles without A edge", d, 3);
    repeat (5) enc_step(1'b0);
    rd(5'h10, 0, d, t);
    chk(d == 32'hFE, "R7 count down wraps", d, 32'hFE);

    rd(5'h1C, 0, d, t);
    chk(d == t / MSL, "R9 timer vs edges", d, t / MSL);
    repeat (60) @(negedge clk);
    rd(5'h1C, 1, d2, t2);
    chk(d2 == t2 / MSL, "R9 timer later", d2, t2 / MSL);
    chk(d2 > d, "R9 timer advanced", d2, d + 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule